// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit half of a packet DMA. Software places descriptors in memory and links them into a ring. Each descriptor is 32 bytes long. Its first three words are the buffer address, a config word and the address of the next descriptor. Software loads the address of the first descriptor into the pointer register and sets the enable bit.

The engine then walks the ring on its own. For each descriptor it reads the three words. If the descriptor holds a frame, the engine reads the buffer one word at a time and streams the bytes out on a valid/ready byte port. It then sets the empty flag in the config word and moves to the next descriptor. When it reaches a descriptor that is already empty, it clears its own enable bit and stops, with the pointer left on that descriptor. Software can refill the ring and enable the engine again. A per-frame tag taken from the config word travels beside the bytes.

Each frame counts as sent only after its write-back has completed. A memory error halts the engine and leaves a sticky flag in the status register.

Top module: `tdr_ring_tx`

## Requirements
- R1: For a descriptor at pointer P, the engine reads the buffer address at P, the config word at P+4 and the next-descriptor address at P+8, in that order. After finishing the descriptor, it continues at the next address, so a ring whose last link points back to the first wraps around.
- R2: A frame is streamed from its buffer, starting at the buffer address. Within each 32-bit word, bytes go out least significant byte first. The byte count comes from config bits 11:0. `tx_last` is high on the final byte only. `tx_tag` carries config bits 16 and up (TAG_W bits) for the whole frame.
- R3: A length in config bits 11:0 greater than BUF_BYTES (2048) is cut to BUF_BYTES bytes.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_tag` hold steady and `tx_valid` stays high.
- R5: After a frame has been sent, the engine writes the config word back to P+4 with bit 31 set and every other bit unchanged. The pointer register then takes the next-descriptor address, and the frame count in status bits 15:0 goes up by one.
- R6: If config bit 31 (empty) is set, the engine sends no bytes and makes no write-back. It clears control bit 0 and stops, with the pointer register left on that descriptor.
- R7: A descriptor that is not empty but has length 0 sends no bytes and is written back with bit 31 set. The engine then advances to the next descriptor, and the frame count does not change.
- R8: A memory response with `mem_err` high sets status bit 31, clears control bit 0 and stops the engine with no further memory access. Writing 1 to status bit 31 clears the flag.
- R9: Register map, selected by `reg_addr`:
  - 0: control; bit 0 is the enable.
  - 1: descriptor pointer; bits 4:0 always read 0.
  - 2: status; bits 15:0 are the frame count, bit 31 is the error flag.
  - 3: reads 0.

  All registers reset to 0. Writes to the pointer are ignored while the enable is set or a descriptor is in progress.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high. Read data and `mem_err` are taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_err | input | 1 | Access failed (valid with mem_ack) |
| mem_rdata | input | 32 | Read data (valid with mem_ack) |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_tag | output | TAG_W | Per-frame tag from the config word |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and that read data and `mem_err` are meaningful only in the acknowledge cycle. They also assume that buffer addresses are word aligned. The bench memory acknowledges each request one cycle after it appears and never on its own. It reports an error only for addresses above its array. The byte sink applies an irregular ready pattern, so stalls land on every byte position. Pointer writes happen while the engine is stopped, except for one deliberate write during a run that must be ignored.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_STRIDE = 32;
    localparam int PTR_LSB     = $clog2(DESC_STRIDE);
    localparam int LEN_W       = 12;
    localparam int TAG_LSB     = 16;
    localparam int FLAG_BIT    = 31;

    localparam logic [WORD_W-1:0] OFS_CFG = 32'd4;
    localparam logic [WORD_W-1:0] OFS_NXT = 32'd8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_PTR  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BUF,
        ST_RD_CFG,
        ST_RD_NXT,
        ST_RD_DATA,
        ST_SEND,
        ST_WB
    } walk_state_e;

    typedef struct packed {
        logic                       empty;
        logic [FLAG_BIT-1:LEN_W]    upper;
        logic [LEN_W-1:0]           len;
    } desc_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(
        input logic [LEN_W-1:0] raw,
        input logic [LEN_W-1:0] cap
    );
        return (raw > cap) ? cap : raw;
    endfunction

endpackage

// File: rtl/tdr_regs.sv
module tdr_regs
    import tdr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              stop,
    input  logic              adv,
    input  logic [WORD_W-1:0] adv_ptr,
    input  logic              frame_done,
    input  logic              err_set,
    output logic              enable,
    output logic [WORD_W-1:0] desc_ptr
);

    logic                       en_q;
    logic [WORD_W-1:PTR_LSB]    ptr_q;
    logic [CNT_W-1:0]           cnt_q;
    logic                       err_q;
    logic                       ptr_lock;
    logic                       unused_bits;

    assign ptr_lock    = en_q || busy;
    assign unused_bits = ^{reg_wdata[FLAG_BIT-1:1], adv_ptr[PTR_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ptr_q <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (stop)
                en_q <= 1'b0;
            else if (reg_we && reg_addr == REG_CTRL)
                en_q <= reg_wdata[0];

            if (adv)
                ptr_q <= adv_ptr[WORD_W-1:PTR_LSB];
            else if (reg_we && reg_addr == REG_PTR && !ptr_lock)
                ptr_q <= reg_wdata[WORD_W-1:PTR_LSB];

            if (frame_done)
                cnt_q <= cnt_q + CNT_W'(1);

            if (err_set)
                err_q <= 1'b1;
            else if (reg_we && reg_addr == REG_STAT && reg_wdata[FLAG_BIT])
                err_q <= 1'b0;
        end
    end

    assign enable   = en_q;
    assign desc_ptr = {ptr_q, {PTR_LSB{1'b0}}};

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = {{(WORD_W-1){1'b0}}, en_q};
            REG_PTR:  reg_rdata = desc_ptr;
            REG_STAT: reg_rdata = {err_q, {(WORD_W-1-CNT_W){1'b0}}, cnt_q};
            default:  reg_rdata = '0;
        endcase
    end

    // R8: an error response leaves the engine disabled and the flag set
    a_r8_err_stops: assert property (@(posedge clk) disable iff (rst)
        err_set |=> (!en_q && err_q));

    // R9: the pointer moves only by advancing while the engine owns it
    a_r9_ptr_locked: assert property (@(posedge clk) disable iff (rst)
        (ptr_lock && !adv) |=> $stable(ptr_q));

endmodule

// File: rtl/tdr_walker.sv
module tdr_walker
    import tdr_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int TAG_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [WORD_W-1:0] desc_ptr,
    output logic              busy,
    output logic              stop,
    output logic              adv,
    output logic [WORD_W-1:0] adv_ptr,
    output logic              frame_done,
    output logic              err_set,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [TAG_W-1:0]  tx_tag
);

    localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

    walk_state_e        state_q;
    desc_cfg_t          cfg_q;
    logic [WORD_W-1:0]  nxt_q;
    logic [WORD_W-1:0]  buf_q;
    logic [WORD_W-1:0]  word_q;
    logic [LEN_W-1:0]   rem_q;
    logic [1:0]         idx_q;
    logic               sent_q;
    logic               ack_ok;
    logic               fetched_empty;

    assign busy    = (state_q != ST_IDLE);
    assign mem_req = (state_q == ST_RD_BUF) || (state_q == ST_RD_CFG) ||
                     (state_q == ST_RD_NXT) || (state_q == ST_RD_DATA) ||
                     (state_q == ST_WB);
    assign mem_we    = (state_q == ST_WB);
    assign mem_wdata = mem_we ? (cfg_q | desc_cfg_t'(32'h8000_0000)) : '0;

    always_comb begin
        case (state_q)
            ST_RD_BUF:  mem_addr = desc_ptr;
            ST_RD_CFG:  mem_addr = desc_ptr + OFS_CFG;
            ST_RD_NXT:  mem_addr = desc_ptr + OFS_NXT;
            ST_RD_DATA: mem_addr = buf_q;
            ST_WB:      mem_addr = desc_ptr + OFS_CFG;
            default:    mem_addr = '0;
        endcase
    end

    assign ack_ok        = mem_req && mem_ack && !mem_err;
    assign err_set       = mem_req && mem_ack && mem_err;
    assign fetched_empty = (state_q == ST_RD_NXT) && ack_ok && cfg_q.empty;
    assign stop          = err_set || fetched_empty;
    assign adv           = (state_q == ST_WB) && ack_ok;
    assign adv_ptr       = nxt_q;
    assign frame_done    = adv && sent_q;

    assign tx_valid = (state_q == ST_SEND);
    assign tx_data  = word_q[{idx_q, 3'b000} +: 8];
    assign tx_last  = tx_valid && (rem_q == LEN_W'(1));
    assign tx_tag   = cfg_q[TAG_LSB +: TAG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            nxt_q   <= '0;
            buf_q   <= '0;
            word_q  <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            sent_q  <= 1'b0;
        end else if (err_set) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    if (enable) state_q <= ST_RD_BUF;
                ST_RD_BUF:
                    if (ack_ok) begin
                        buf_q   <= mem_rdata;
                        state_q <= ST_RD_CFG;
                    end
                ST_RD_CFG:
                    if (ack_ok) begin
                        cfg_q   <= desc_cfg_t'(mem_rdata);
                        state_q <= ST_RD_NXT;
                    end
                ST_RD_NXT:
                    if (ack_ok) begin
                        nxt_q <= mem_rdata;
                        if (cfg_q.empty) begin
                            state_q <= ST_IDLE;
                        end else if (cfg_q.len == '0) begin
                            sent_q  <= 1'b0;
                            state_q <= ST_WB;
                        end else begin
                            rem_q   <= clamp_len(cfg_q.len, CAP);
                            sent_q  <= 1'b1;
                            state_q <= ST_RD_DATA;
                        end
                    end
                ST_RD_DATA:
                    if (ack_ok) begin
                        word_q  <= mem_rdata;
                        idx_q   <= '0;
                        buf_q   <= buf_q + 32'd4;
                        state_q <= ST_SEND;
                    end
                ST_SEND:
                    if (tx_ready) begin
                        rem_q <= rem_q - LEN_W'(1);
                        idx_q <= idx_q + 2'd1;
                        if (rem_q == LEN_W'(1))
                            state_q <= ST_WB;
                        else if (idx_q == 2'd3)
                            state_q <= ST_RD_DATA;
                    end
                ST_WB:
                    if (ack_ok) state_q <= ST_IDLE;
                default:
                    state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: a stalled byte is held unchanged
    a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_tag)));

    // R10: a request is held with a stable address until acknowledged
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8: after an error response nothing else is issued
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> (!mem_req && !tx_valid));

    // R2: the final byte ends the stream for that frame
    a_r2_last_ends: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    // R6: an empty descriptor produces neither bytes nor a write-back
    a_r6_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        fetched_empty |=> (!mem_req && !tx_valid));

endmodule

// File: rtl/tdr_ring_tx.sv
module tdr_ring_tx
    import tdr_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int TAG_W     = 4,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [TAG_W-1:0]  tx_tag
);

    logic              enable;
    logic [WORD_W-1:0] desc_ptr;
    logic              busy;
    logic              stop;
    logic              adv;
    logic [WORD_W-1:0] adv_ptr;
    logic              frame_done;
    logic              err_set;

    tdr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .stop       (stop),
        .adv        (adv),
        .adv_ptr    (adv_ptr),
        .frame_done (frame_done),
        .err_set    (err_set),
        .enable     (enable),
        .desc_ptr   (desc_ptr)
    );

    tdr_walker #(.BUF_BYTES(BUF_BYTES), .TAG_W(TAG_W)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .desc_ptr   (desc_ptr),
        .busy       (busy),
        .stop       (stop),
        .adv        (adv),
        .adv_ptr    (adv_ptr),
        .frame_done (frame_done),
        .err_set    (err_set),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_tag     (tx_tag)
    );

endmodule

// File: tb/tdr_ring_tx_tb.sv
`timescale 1ns/1ps
module tdr_ring_tx_tb;

    localparam int BUF_BYTES = 2048;
    localparam int TAG_W     = 4;
    localparam logic [1:0] A_CTRL = 2'd0, A_PTR = 2'd1, A_STAT = 2'd2, A_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic [TAG_W-1:0] tx_tag;

    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0, host_data = '0;
    logic [31:0] mem [0:4095];

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;
    bit done = 1'b0;

    logic [12:0] exp_q[$];
    logic [31:0] wb_addr[$];
    logic [31:0] wb_data[$];

    logic        hold_pend = 1'b0;
    logic [12:0] hold_val = '0;
    logic        mreq_pend = 1'b0;
    logic [31:0] mreq_addr = '0;

    always #2 clk = ~clk;

    tdr_ring_tx #(.BUF_BYTES(BUF_BYTES), .TAG_W(TAG_W), .CNT_W(16)) u_dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_tag(tx_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: one wait cycle, error above the array
    always @(posedge clk) begin
        if (host_we) mem[host_addr[13:2]] <= host_data;
        if (rst) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_addr >= 32'h4000) begin
                mem_err   <= 1'b1;
                mem_rdata <= '0;
            end else begin
                mem_err   <= 1'b0;
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    always @(posedge clk) begin
        rdy_cnt  <= rdy_cnt + 1;
        tx_ready <= ((rdy_cnt % 7) != 3) && ((rdy_cnt % 5) != 1);
    end

    // per-cycle comparison against the reference stream
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend)
                check(tx_valid && {tx_tag, tx_last, tx_data} == hold_val, "R4",
                      "stalled byte changed", {19'd0, tx_tag, tx_last, tx_data}, {19'd0, hold_val});
            hold_pend = tx_valid && !tx_ready;
            hold_val  = {tx_tag, tx_last, tx_data};

            if (mreq_pend)
                check(mem_req && mem_addr == mreq_addr, "R10", "request dropped or moved",
                      mem_addr, mreq_addr);
            mreq_pend = mem_req && !mem_ack;
            mreq_addr = mem_addr;

            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected byte", {19'd0, tx_tag, tx_last, tx_data}, 32'd0);
                end else begin
                    logic [12:0] e;
                    e = exp_q.pop_front();
                    check({tx_tag, tx_last, tx_data} == e, "R2", "byte/tag/last",
                          {19'd0, tx_tag, tx_last, tx_data}, {19'd0, e});
                end
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic host_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[13:2]];
        return w[{a[1:0], 3'b000} +: 8];
    endfunction

    // reference walk of the ring, from the requirements
    task automatic build(input logic [31:0] start, output logic [31:0] endp, output int nfr);
        logic [31:0] p, cfg, bufa, q;
        int len;
        p = start;
        nfr = 0;
        for (int g = 0; g < 8; g++) begin
            q    = p + 32'd4;
            cfg  = mem[q[13:2]];
            if (cfg[31]) break;
            bufa = mem[p[13:2]];
            len  = int'(cfg[11:0]);
            if (len > BUF_BYTES) len = BUF_BYTES;
            for (int k = 0; k < len; k++)
                exp_q.push_back({cfg[16 +: TAG_W], (k == len - 1), mbyte(bufa + k)});
            if (len > 0) nfr++;
            wb_addr.push_back(q);
            wb_data.push_back(cfg | 32'h8000_0000);
            q = p + 32'd8;
            p = mem[q[13:2]] & ~32'd31;
        end
        endp = p;
    endtask

    task automatic wait_stop();
        logic [31:0] d;
        for (int n = 0; n < 30000; n++) begin
            reg_read(A_CTRL, d);
            if (!d[0]) return;
        end
        check(1'b0, "R6", "engine never stopped", 32'd1, 32'd0);
    endtask

    task automatic check_wb(input string req);
        while (wb_addr.size() > 0) begin
            logic [31:0] a, d;
            a = wb_addr.pop_front();
            d = wb_data.pop_front();
            check(mem[a[13:2]] == d, req, "config write-back", mem[a[13:2]], d);
        end
    endtask

    initial begin
        logic [31:0] d, endp;
        int nfr;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        reg_read(A_CTRL, d); check(d == 0, "R9", "ctrl after reset", d, 0);
        reg_read(A_PTR,  d); check(d == 0, "R9", "ptr after reset", d, 0);
        reg_read(A_STAT, d); check(d == 0, "R9", "status after reset", d, 0);
        reg_read(A_NONE, d); check(d == 0, "R9", "unused address", d, 0);
        check(!tx_valid && !mem_req, "R9", "idle outputs after reset", {tx_valid, mem_req}, 0);

        // buffers and ring of four descriptors
        for (int i = 0; i < 4; i++)
            for (int w = 0; w < 512; w++) begin
                logic [31:0] word;
                for (int k = 0; k < 4; k++)
                    word[8*k +: 8] = 8'((i * 37 + (4 * w + k) * 5 + 1) & 255);
                host_write(32'h1000 + 32'(i) * 32'h800 + 32'(4 * w), word);
            end
        for (int i = 0; i < 4; i++) begin
            host_write(32'(32 * i),     32'h1000 + 32'(i) * 32'h800);
            host_write(32'(32 * i + 8), 32'(32 * ((i + 1) % 4)));
        end
        host_write(32'h04, (32'd3 << 16) | 32'd5);
        host_write(32'h24, 32'd0);
        host_write(32'h44, (32'd10 << 16) | 32'd3000);
        host_write(32'h64, 32'h8000_0000);

        // run 1: frame, zero-length, oversize frame, empty stop
        build(32'h0, endp, nfr);
        reg_write(A_PTR, 32'h0);
        reg_write(A_CTRL, 32'h1);
        wait_stop();
        check(exp_q.size() == 0, "R3", "bytes still expected (oversize cut)", exp_q.size(), 0);
        reg_read(A_STAT, d); check(d == 32'd2, "R7", "count skips zero-length", d, 2);
        reg_read(A_PTR, d);  check(d == endp, "R6", "pointer left on empty", d, endp);
        check(mem[32'h24 >> 2] == 32'h8000_0000, "R7", "zero-length write-back", mem[32'h24 >> 2], 32'h8000_0000);
        check(mem[32'h64 >> 2] == 32'h8000_0000, "R6", "empty descriptor untouched", mem[32'h64 >> 2], 32'h8000_0000);
        check_wb("R5");

        // run 2: start at the last descriptor, wrap to the first
        host_write(32'h64, (32'd1 << 16) | 32'd1);
        host_write(32'h04, (32'd5 << 16) | 32'd7);
        reg_write(A_PTR, 32'h60);
        build(32'h60, endp, nfr);
        reg_write(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        reg_write(A_PTR, 32'h40);
        wait_stop();
        check(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
        reg_read(A_PTR, d);  check(d == 32'h20, "R1", "wrapped pointer, busy write ignored (R9)", d, 32'h20);
        reg_read(A_STAT, d); check(d == 32'd4, "R5", "frame count", d, 4);
        check_wb("R5");

        // run 3: memory error
        reg_write(A_PTR, 32'h8000);
        reg_write(A_CTRL, 32'h1);
        wait_stop();
        reg_read(A_STAT, d); check(d == 32'h8000_0004, "R8", "error flag set", d, 32'h8000_0004);
        reg_read(A_CTRL, d); check(d == 0, "R8", "enable cleared", d, 0);
        reg_write(A_STAT, 32'h8000_0000);
        reg_read(A_STAT, d); check(d == 32'd4, "R8", "error flag cleared", d, 4);
        check(exp_q.size() == 0, "R8", "no bytes on error", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule